// File: doc/BRIEF.md
# Gated Clock-Pulse Pattern Generator

This block is a small sequencer that waits idle until a start request arrives and then walks a fixed chain of states. Three consecutive states form an output window of three clock slots. In each slot the pulse output either copies the whole high half of the clock or stays low. The first slot always carries a pulse and the second never does. The third slot carries a pulse only when the select input is high. The three slots therefore read 101 with select high and 100 with select low.

The output is Mealy-style, decoded from the state together with the clock level and the select input. A change of select during the third slot shows up on the output in that same cycle. The state register uses a cyclic Gray assignment of six codes, one of which is a padding state placed after the window. As a result, every legal transition flips exactly one state bit. The current state code is brought out so that the sequence can be observed. When start is held high, patterns follow one another with a single idle cycle between them.

Top module: `pulse_pattern_gen`

## Requirements
- R1: When rst_n is low at a rising clock edge, the state code becomes 000 after that edge, and pulse_out stays low until a new pattern is started.
- R2: In the idle state (code 000) with start low, the machine stays idle and pulse_out remains low.
- R3: A rising edge that samples start high in the idle state moves the machine to 001. The following edges step it unconditionally through 011, 111, 110 and 100, and then back to 000.
- R4: Any two consecutive state codes seen during operation differ in exactly one bit.
- R5: In state 001 (first slot), pulse_out is high during the clock-high phase and low during the clock-low phase.
- R6: In states 011, 110, 100 and 000, pulse_out is low in both clock phases.
- R7: In state 111 (third slot), pulse_out equals the clock level ANDed with sel_last. With sel_last=1 the window gives 101, and with sel_last=0 it gives 100.
- R8: A change of sel_last while the machine is in state 111 changes pulse_out within the same clock-high phase, without waiting for a clock edge.
- R9: sel_last has no effect on pulse_out outside state 111. In particular, the first slot pulses whatever the value of sel_last.
- R10: With start held high, the machine re-enters 001 at the first edge after it returns to 000, so patterns repeat with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its high phase is copied onto pulse_out in active slots |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a pattern when sampled high in the idle state |
| sel_last | input | 1 | Enables the pulse in the third slot |
| pulse_out | output | 1 | Clock-qualified pulse pattern output |
| state_code | output | 3 | Current state register value |

## Verification
The assertions assume that start and sel_last are stable across each rising clock edge. They also assume that sel_last changes only while the clock is low, except in the deliberate same-cycle test of R8, which takes place in the high phase of state 111 and away from any edge. The phase checks sample pulse_out just before each clock edge, so a glitch-free clock is taken for granted. The bench drives every input from the falling edge or from the middle of a high phase, and it samples outputs two nanoseconds after an edge, so no stimulus moves at the instant a property samples it.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_SLOT1 = 3'b001,
    ST_SLOT2 = 3'b011,
    ST_SLOT3 = 3'b111,
    ST_TAIL  = 3'b110,
    ST_PAD   = 3'b100
  } ppg_state_e;

  // Successor of a state code; illegal codes fall back to idle.
  function automatic logic [STATE_W-1:0] ppg_next(input logic [STATE_W-1:0] cur,
                                                  input logic go);
    logic [STATE_W-1:0] nxt;
    case (cur)
      ST_IDLE:  nxt = go ? ST_SLOT1 : ST_IDLE;
      ST_SLOT1: nxt = ST_SLOT2;
      ST_SLOT2: nxt = ST_SLOT3;
      ST_SLOT3: nxt = ST_TAIL;
      ST_TAIL:  nxt = ST_PAD;
      ST_PAD:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // True for the six codes of the Gray cycle.
  function automatic logic ppg_is_legal(input logic [STATE_W-1:0] cur);
    return (cur == ST_IDLE) || (cur == ST_SLOT1) || (cur == ST_SLOT2) ||
           (cur == ST_SLOT3) || (cur == ST_TAIL)  || (cur == ST_PAD);
  endfunction

  // Slot enable before clock qualification.
  function automatic logic ppg_slot_enable(input logic [STATE_W-1:0] cur,
                                           input logic sel);
    return (cur == ST_SLOT1) || ((cur == ST_SLOT3) && sel);
  endfunction

endpackage

// File: rtl/ppg_next_logic.sv
module ppg_next_logic
  import ppg_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic               start,
  output logic [STATE_W-1:0] nxt_state,
  output logic               launch,
  output logic               recover
);

  always_comb begin
    nxt_state = ppg_next(cur_state, start);
    launch    = (cur_state == ST_IDLE) && start;
    recover   = !ppg_is_legal(cur_state);
  end

endmodule

// File: rtl/ppg_state_reg.sv
module ppg_state_reg
  import ppg_pkg::*;
#(
  parameter logic [STATE_W-1:0] RESET_CODE = ST_IDLE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] nxt_state,
  output logic [STATE_W-1:0] cur_state
);

  always_ff @(posedge clk) begin
    if (!rst_n) cur_state <= RESET_CODE;
    else        cur_state <= nxt_state;
  end

endmodule

// File: rtl/ppg_pulse_gate.sv
module ppg_pulse_gate
  import ppg_pkg::*;
(
  input  logic               clk,
  input  logic [STATE_W-1:0] cur_state,
  input  logic               sel,
  output logic               slot_en,
  output logic               pulse
);

  always_comb begin
    slot_en = ppg_slot_enable(cur_state, sel);
    pulse   = slot_en & clk;
  end

endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
  import ppg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sel_last,
  output logic               pulse_out,
  output logic [STATE_W-1:0] state_code
);

  logic [STATE_W-1:0] cur_state;
  logic [STATE_W-1:0] nxt_state;
  logic               seq_launch;
  logic               seq_recover;
  logic               slot_en;

  ppg_next_logic u_next (
    .cur_state (cur_state),
    .start     (start),
    .nxt_state (nxt_state),
    .launch    (seq_launch),
    .recover   (seq_recover)
  );

  ppg_state_reg #(.RESET_CODE(ST_IDLE)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  ppg_pulse_gate u_gate (
    .clk       (clk),
    .cur_state (cur_state),
    .sel       (sel_last),
    .slot_en   (slot_en),
    .pulse     (pulse_out)
  );

  assign state_code = cur_state;

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker
  import ppg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               sel_last,
  input logic               pulse_out,
  input logic [STATE_W-1:0] state_code,
  input logic               seq_launch,
  input logic               seq_recover
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (state_code == ST_IDLE));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_IDLE && !start) |=> (state_code == ST_IDLE));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> (state_code == ST_SLOT1));

  // R3
  mid_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_SLOT3) |=> (state_code == ST_TAIL));

  // R3
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_recover |=> (state_code == ST_IDLE));

  // R4
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && state_code != $past(state_code)) |->
      ($countones(state_code ^ $past(state_code)) == 1));

  // R5
  first_slot_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (state_code == ST_SLOT1) |-> pulse_out);

  // R6
  quiet_state_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (state_code == ST_SLOT2 || state_code == ST_TAIL ||
     state_code == ST_PAD   || state_code == ST_IDLE) |-> !pulse_out);

  // R7
  low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_out);

endmodule

bind pulse_pattern_gen ppg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .sel_last    (sel_last),
  .pulse_out   (pulse_out),
  .state_code  (state_code),
  .seq_launch  (seq_launch),
  .seq_recover (seq_recover)
);

// File: tb/pulse_pattern_gen_tb.sv
`timescale 1ns/1ps
module pulse_pattern_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       sel_last = 1'b0;
  logic       pulse_out;
  logic [2:0] state_code;

  int n_run  = 0;
  int n_fail = 0;
  logic [2:0] prev_code = 3'b000;
  int hi_count = 0;

  always #5 clk = ~clk;

  pulse_pattern_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sel_last   (sel_last),
    .pulse_out  (pulse_out),
    .state_code (state_code)
  );

  // sel value, expected slot bits (slot1, slot2, slot3)
  typedef struct packed { logic sel; logic [2:0] slots; } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b0, 3'b100}, '{1'b1, 3'b101}, '{1'b1, 3'b101}, '{1'b0, 3'b100}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // High-phase sample after a rising edge: state code, pulse, one-bit step.
  task automatic hi_step(input logic [2:0] exp_code, input logic exp_p, input string req);
    @(posedge clk); #2;
    check({req, " state"}, {5'd0, state_code}, {5'd0, exp_code});
    check({req, " pulse hi"}, {7'd0, pulse_out}, {7'd0, exp_p});
    if (state_code != prev_code)
      check("R4 one-bit step", 8'($countones(state_code ^ prev_code)), 8'd1);
    if (pulse_out) hi_count++;
    prev_code = state_code;
  endtask

  task automatic lo_phase(input string req);
    @(negedge clk); #2;
    check({req, " pulse lo"}, {7'd0, pulse_out}, 8'd0);
  endtask

  task automatic run_pattern(input logic sel, input logic [2:0] slots);
    @(negedge clk); start = 1'b1; sel_last = sel;
    hi_count = 0;
    hi_step(3'b001, slots[2], "R5 R3 slot1");
    @(negedge clk); start = 1'b0; #2;
    check("R5 slot1 low phase", {7'd0, pulse_out}, 8'd0);
    hi_step(3'b011, slots[1], "R6 R3 slot2"); lo_phase("R6 slot2");
    hi_step(3'b111, slots[0], "R7 R3 slot3"); lo_phase("R7 slot3");
    check("R7 window pulse count", 8'(hi_count), 8'($countones(slots)));
    hi_step(3'b110, 1'b0, "R6 R3 tail"); lo_phase("R6 tail");
    hi_step(3'b100, 1'b0, "R6 R3 pad");  lo_phase("R6 pad");
    hi_step(3'b000, 1'b0, "R6 R3 idle"); lo_phase("R6 idle");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset state", {5'd0, state_code}, 8'd0);
    check("R1 reset pulse", {7'd0, pulse_out}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    prev_code = 3'b000;

    // R2 idle hold with start low
    for (int i = 0; i < 3; i++) hi_step(3'b000, 1'b0, "R2 idle");

    // table walk: R3 R5 R6 R7
    for (int v = 0; v < 4; v++) run_pattern(VECS[v].sel, VECS[v].slots);

    // R9: sel low still gives slot1 pulse; sel high gives none in slot2
    @(negedge clk); start = 1'b1; sel_last = 1'b0;
    hi_step(3'b001, 1'b1, "R9 slot1 sel=0");
    @(negedge clk); start = 1'b0; sel_last = 1'b1;
    hi_step(3'b011, 1'b0, "R9 slot2 sel=1");
    // R8: same-cycle follow in slot3
    @(negedge clk); sel_last = 1'b0;
    hi_step(3'b111, 1'b0, "R8 slot3 sel=0");
    sel_last = 1'b1; #1;
    check("R8 sel rise in slot3", {7'd0, pulse_out}, 8'd1);
    sel_last = 1'b0; #1;
    check("R8 sel fall in slot3", {7'd0, pulse_out}, 8'd0);
    @(negedge clk); sel_last = 1'b1;
    hi_step(3'b110, 1'b0, "R9 tail sel=1");
    hi_step(3'b100, 1'b0, "R9 pad sel=1");
    hi_step(3'b000, 1'b0, "R9 idle sel=1");

    // R10: start held high repeats with one idle cycle
    @(negedge clk); start = 1'b1;
    hi_step(3'b001, 1'b1, "R10 first slot1");
    hi_step(3'b011, 1'b0, "R10 slot2");
    hi_step(3'b111, 1'b1, "R10 slot3");
    hi_step(3'b110, 1'b0, "R10 tail");
    hi_step(3'b100, 1'b0, "R10 pad");
    hi_step(3'b000, 1'b0, "R10 idle gap");
    hi_step(3'b001, 1'b1, "R10 relaunch");

    // R1: reset mid-pattern
    @(negedge clk); start = 1'b0; rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1 mid-pattern reset state", {5'd0, state_code}, 8'd0);
    check("R1 mid-pattern reset pulse", {7'd0, pulse_out}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    prev_code = 3'b000;
    hi_step(3'b000, 1'b0, "R1 R2 after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule